// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is the bus-facing half of a small CPU. It takes one request at a time and runs it as a single external machine cycle. A request names the cycle kind, a full address and a write byte. The cycle kinds are instruction fetch, memory read, memory write, port read and port write. The low address byte and the data byte share one set of lines. The block puts the address there first and marks it with a latch-enable pulse. It then hands the lines to the data transfer. The upper address byte has lines of its own and stays up for the whole access.

Every cycle carries a three-bit tag: a space-select line (memory or port) and two status lines. This tag lets external logic tell the kinds apart. The block divides the incoming oscillator clock to make its state clock, and puts that state clock out on a pin for the rest of the system. Read data is returned on a register together with a one-clock completion pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is applied, the outputs are idle: ale=0, rd_n=1, wr_n=1, ad_oe=0, done=0, space_io=0, stat1=0, stat0=0, addr_hi=0 and rdata=0.
- R2: One T-state lasts DIV oscillator cycles (DIV=2 by default). clk_out is high for the first half of each T-state and low for the second half.
- R3: In T1, addr_hi carries address bits [15:8], ad_out carries bits [7:0], ad_oe=1 and ale=1.
- R4: ale is 0 in every T-state other than T1.
- R5: The tag {space_io,stat1,stat0} is 011 for a fetch, 010 for a memory read, 001 for a memory write, 110 for a port read and 101 for a port write. It is valid from the start of T1 to the end of the cycle and is 000 when idle.
- R6: For the read kinds (fetch, memory read, port read), rd_n=0 and ad_oe=0 in T2 and T3. rd_n=1 in T1 and T4.
- R7: For the write kinds, wr_n=0, ad_oe=1 and ad_out equals the write byte in T2 and T3. rd_n stays 1 for the whole cycle.
- R8: addr_hi holds the request's upper address byte in every T-state of the cycle.
- R9: A fetch lasts four T-states and every other kind lasts three. done is high for exactly one oscillator cycle, right after the last T-state ends.
- R10: rdata takes the value of ad_in on the clock edge that ends T3 of a read kind. Values that ad_in holds in T2 or T4 are not taken.
- R11: req_kind codes are 0 fetch, 1 memory read, 2 memory write, 3 port read and 4 port write. A request with code 5, 6 or 7 is ignored and starts no cycle.
- R12: req_ready is high in the last oscillator cycle of each idle T-state and of the final T-state of a cycle. A legal request seen with req_ready high starts T1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted on the next edge if valid |
| addr_hi | output | 8 | Dedicated upper address lines |
| ad_out | output | 8 | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines driver enable |
| ad_in | input | 8 | Shared lines, received value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| space_io | output | 1 | 1 for port cycles, 0 for memory cycles |
| stat1 | output | 1 | Status line 1 |
| stat0 | output | 1 | Status line 0 |
| clk_out | output | 1 | State clock out |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | Cycle complete pulse |

## Verification
A request is accepted on the edge that follows a sample showing req_ready high. From that edge, T-state k takes oscillator cycles 2(k-1) and 2(k-1)+1. The bench samples every pin at the falling edge in both halves of every T-state and compares it with values it works out from the kind, the address and the write byte. done and rdata are due in the oscillator cycle after the edge that ends the final T-state, so they are checked at the next falling edge and again one cycle later. ad_in changes from a decoy value to the real byte at T3 and back to a decoy in T4, which shows which edge the capture uses.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_PRD   = 3'd3,
      K_PWR   = 3'd4
   } cyc_kind_e;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_T4   = 3'd4
   } tstate_e;

   typedef struct packed {
      logic space_io;
      logic st1;
      logic st0;
   } cyc_tag_t;

   function automatic logic kind_legal(input logic [2:0] k);
      return k <= 3'd4;
   endfunction

   function automatic logic kind_writes(input cyc_kind_e k);
      return (k == K_MWR) || (k == K_PWR);
   endfunction

   function automatic cyc_tag_t tag_of(input cyc_kind_e k);
      cyc_tag_t t;
      case (k)
         K_FETCH: t = '{space_io: 1'b0, st1: 1'b1, st0: 1'b1};
         K_MRD:   t = '{space_io: 1'b0, st1: 1'b1, st0: 1'b0};
         K_MWR:   t = '{space_io: 1'b0, st1: 1'b0, st0: 1'b1};
         K_PRD:   t = '{space_io: 1'b1, st1: 1'b1, st0: 1'b0};
         K_PWR:   t = '{space_io: 1'b1, st1: 1'b0, st0: 1'b1};
         default: t = '0;
      endcase
      return t;
   endfunction

   function automatic tstate_e final_state(input cyc_kind_e k);
      return (k == K_FETCH) ? TS_T4 : TS_T3;
   endfunction

endpackage

// File: rtl/tstate_clkgen.sv
module tstate_clkgen #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic clk_out
);
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;

   initial begin
      assert (DIV >= 2 && (DIV % 2) == 0)
         else $error("tstate_clkgen: DIV must be even and at least 2");
   end

   generate
      if (DIV == 2) begin : g_toggle
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph <= 1'b0;
            else        ph <= ~ph;
         end
         assign tick    = ph;
         assign clk_out = ~ph;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (cnt == CW'(DIV - 1)) cnt <= '0;
            else                          cnt <= cnt + 1'b1;
         end
         assign tick    = (cnt == CW'(DIV - 1));
         assign clk_out = (cnt < CW'(HALF));
      end
   endgenerate

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
   import bus_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output tstate_e           state,
   output cyc_kind_e         kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              cycle_end
);
   logic at_final;
   logic can_take;
   logic take;

   assign at_final  = (state == final_state(kind_q));
   assign can_take  = (state == TS_IDLE) || at_final;
   assign req_ready = tick && can_take;
   assign take      = req_ready && req_valid && kind_legal(req_kind);
   assign cycle_end = tick && at_final;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TS_IDLE;
         kind_q  <= K_MRD;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (take) begin
         state   <= TS_T1;
         kind_q  <= cyc_kind_e'(req_kind);
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end else if (tick) begin
         case (state)
            TS_T1:   state <= TS_T2;
            TS_T2:   state <= TS_T3;
            TS_T3:   state <= at_final ? TS_IDLE : TS_T4;
            default: state <= TS_IDLE;
         endcase
      end
   end

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(state)); // R9
   AST_T4_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_T4) |-> (kind_q == K_FETCH)); // R9

endmodule

// File: rtl/bus_pin_decode.sv
module bus_pin_decode
   import bus_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  tstate_e                  state,
   input  cyc_kind_e                kind_q,
   input  logic [ADDR_W-1:0]        addr_q,
   input  logic [DATA_W-1:0]        wdata_q,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     space_io,
   output logic                     stat1,
   output logic                     stat0
);
   localparam int LO_W = DATA_W;

   logic     active;
   logic     in_t1;
   logic     strobe_win;
   logic     wr_kind;
   cyc_tag_t tag;

   assign active     = (state != TS_IDLE);
   assign in_t1      = (state == TS_T1);
   assign strobe_win = (state == TS_T2) || (state == TS_T3);
   assign wr_kind    = kind_writes(kind_q);
   assign tag        = active ? tag_of(kind_q) : '0;

   always_comb begin
      addr_hi  = active ? addr_q[ADDR_W-1:LO_W] : '0;
      ale      = in_t1;
      ad_oe    = in_t1 || (strobe_win && wr_kind);
      if (in_t1)                     ad_out = addr_q[LO_W-1:0];
      else if (strobe_win && wr_kind) ad_out = wdata_q;
      else                           ad_out = '0;
      rd_n     = !(strobe_win && !wr_kind);
      wr_n     = !(strobe_win && wr_kind);
      space_io = tag.space_io;
      stat1    = tag.st1;
      stat0    = tag.st0;
   end

   AST_ALE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> ad_oe); // R3
   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe); // R6
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n || wr_n); // R7
   AST_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ale) |-> $stable(addr_hi)); // R8

endmodule

// File: rtl/read_capture.sv
module read_capture
   import bus_seq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  tstate_e           state,
   input  cyc_kind_e         kind_q,
   input  logic              cycle_end,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   logic grab;
   assign grab = tick && (state == TS_T3) && !kind_writes(kind_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         if (grab) rdata <= ad_in;
         done <= cycle_end;
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bus_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int DIV    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [2:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_ready,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     space_io,
   output logic                     stat1,
   output logic                     stat0,
   output logic                     clk_out,
   output logic [DATA_W-1:0]        rdata,
   output logic                     done
);
   initial begin
      assert (ADDR_W > DATA_W)
         else $error("bus_cycle_seq: ADDR_W must exceed DATA_W");
   end

   logic              tick;
   logic              cycle_end;
   tstate_e           state;
   cyc_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   tstate_clkgen #(.DIV(DIV)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .clk_out (clk_out)
   );

   cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .state     (state),
      .kind_q    (kind_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .cycle_end (cycle_end)
   );

   bus_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .kind_q   (kind_q),
      .addr_q   (addr_q),
      .wdata_q  (wdata_q),
      .addr_hi  (addr_hi),
      .ad_out   (ad_out),
      .ad_oe    (ad_oe),
      .ale      (ale),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .space_io (space_io),
      .stat1    (stat1),
      .stat0    (stat0)
   );

   read_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .state     (state),
      .kind_q    (kind_q),
      .cycle_end (cycle_end),
      .ad_in     (ad_in),
      .rdata     (rdata),
      .done      (done)
   );

   AST_STROBE_NOT_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n)); // R4

endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        req_ready;
   logic [7:0]  addr_hi;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  ad_in = 8'h00;
   logic        ale, rd_n, wr_n, space_io, stat1, stat0, clk_out, done;
   logic [7:0]  rdata;

   int n_vec  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bus_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .space_io(space_io),
      .stat1(stat1), .stat0(stat0), .clk_out(clk_out), .rdata(rdata), .done(done)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [2:0] exp_tag(input int k);
      case (k)
         0: return 3'b011;
         1: return 3'b010;
         2: return 3'b001;
         3: return 3'b110;
         default: return 3'b101;
      endcase
   endfunction

   task automatic run_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                            input logic [7:0] rd_val);
      int  n  = (k == 0) ? 4 : 3;
      bit  wr = (k == 2) || (k == 4);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_addr = a; req_wdata = wd;
      ad_in = ~rd_val;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 1; t <= n; t++) begin
         for (int h = 0; h < 2; h++) begin
            if (!(t == 1 && h == 0)) @(negedge clk);
            if (t == 3 && h == 0) ad_in = rd_val;
            if (t == 4 && h == 0) ad_in = rd_val ^ 8'hFF;
            check("R2 clk_out", 16'(clk_out), 16'(h == 0));
            check("R3/R4 ale", 16'(ale), 16'(t == 1));
            check("R8 addr_hi", 16'(addr_hi), 16'(a[15:8]));
            check("R5 tag", 16'({space_io, stat1, stat0}), 16'(exp_tag(k)));
            check("R6 rd_n", 16'(rd_n), 16'(!(!wr && (t == 2 || t == 3))));
            check("R7 wr_n", 16'(wr_n), 16'(!(wr && (t == 2 || t == 3))));
            check("R3/R7 ad_oe", 16'(ad_oe), 16'(t == 1 || (wr && (t == 2 || t == 3))));
            if (t == 1) check("R3 ad_out", 16'(ad_out), 16'(a[7:0]));
            else if (wr && t <= 3) check("R7 ad_out", 16'(ad_out), 16'(wd));
            check("R12 req_ready", 16'(req_ready), 16'(h == 1 && t == n));
            check("R9 done low", 16'(done), 16'h0);
         end
      end
      @(negedge clk);
      check("R9 done pulse", 16'(done), 16'h1);
      check("R5 idle tag", 16'({space_io, stat1, stat0}), 16'h0);
      check("R4 ale idle", 16'(ale), 16'h0);
      if (!wr) check("R10 rdata", 16'(rdata), 16'(rd_val));
      @(negedge clk);
      check("R9 done single", 16'(done), 16'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] last_rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ale", 16'(ale), 16'h0);
      check("R1 rd_n", 16'(rd_n), 16'h1);
      check("R1 wr_n", 16'(wr_n), 16'h1);
      check("R1 ad_oe", 16'(ad_oe), 16'h0);
      check("R1 done", 16'(done), 16'h0);
      check("R1 tag", 16'({space_io, stat1, stat0}), 16'h0);
      check("R1 addr_hi", 16'(addr_hi), 16'h0);
      check("R1 rdata", 16'(rdata), 16'h0);
      rst_n = 1'b1;
      last_rd = 8'h00;
      for (int i = 0; i < 10; i++) begin
         for (int k = 0; k < 5; k++) begin
            logic [15:0] a  = 16'(i * 16'h1357 + k * 16'h0F1 + 16'h2005);
            logic [7:0]  wd = 8'(i * 29 + k * 7 + 3);
            logic [7:0]  rv = a[7:0] ^ a[15:8] ^ 8'(k + 8'h3C);
            run_cycle(k, a, wd, rv);
            if (!(k == 2 || k == 4)) last_rd = rv;
            else check("R10 rdata kept on write", 16'(rdata), 16'(last_rd));
         end
      end
      // R11 illegal kind codes start nothing
      for (int k = 5; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'hBEEF;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check("R11 ale", 16'(ale), 16'h0);
            check("R11 ad_oe", 16'(ad_oe), 16'h0);
            check("R11 strobes", 16'({rd_n, wr_n}), 16'h3);
            check("R11 tag", 16'({space_io, stat1, stat0}), 16'h0);
            check("R11 done", 16'(done), 16'h0);
         end
         req_valid = 1'b0;
      end
      run_cycle(1, 16'hFFFF, 8'h00, 8'h81);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule